// File: doc/BRIEF.md
# Sector Read DMA Controller

This block lets a processor fetch one 512-byte disk sector into main memory and then forget about it until the transfer is over. Software loads a logical block number and a memory destination into two registers, then sets the start bit in a command register. From that point on, the controller works alone. It turns the logical block number into a surface, track and sector position from fixed geometry parameters and presents that position to the sector source. It takes the sector's bytes one at a time over a valid/ready port, packs them into 32-bit words and writes those words to consecutive memory addresses through a simple write master that waits on a ready signal. When the last word has been written, it raises an interrupt.

A logical block number at or beyond the disk capacity produces no transfer. It sets an error flag and raises the interrupt at once, so software learns of the failure along the same path as a completion. The interrupt and all completion and error flags stay set until software writes the clear bit of the status register.

Top module: `sector_dma_ctrl`

## Requirements
- R1: After reset, `irq`, `mem_wr` and `sd_ready` are low and the status register (register index 3) reads 0.
- R2: While a transfer runs, `chs_sector` = lbn mod S, `chs_surface` = (lbn / S) mod H and `chs_track` = lbn / (S*H). With the defaults S=16, H=4 and T=64, the capacity is 4096 blocks.
- R3: A transfer writes exactly 128 words. Word k goes to address (dest with its two low bits cleared) + 4k. Word k holds sector bytes 4k..4k+3, with byte 4k in bits 7:0 (least significant byte first).
- R4: Once `mem_wr` is high, it stays high, and `mem_addr` and `mem_wdata` hold steady, until a cycle in which `mem_ready` is high.
- R5: After the last word is accepted, `irq` goes high, busy (status bit 0) goes low and done (status bit 1) goes high.
- R6: `irq` stays high until software writes status (index 3) with bit 0 set. That write clears `irq`, done, start error and range error.
- R7: Writing the command register (index 0) with bit 0 set while busy has no effect on the running transfer. It sets the start-error flag (status bit 2).
- R8: A start with a logical block number at or above the capacity writes no memory and does not go busy. It sets range error (status bit 3) and `irq` on the next cycle.
- R9: Register index 1 (block number) and index 2 (destination) read back the last values written. Status bit 4 mirrors `irq`.
- R10: `sd_ready` is high only while busy and while no word is waiting to be written to memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index: 0 command, 1 block number, 2 destination, 3 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the register selected by reg_addr (combinational) |
| chs_sector | output | $clog2(S) | Sector within the track |
| chs_surface | output | $clog2(H) | Surface number |
| chs_track | output | $clog2(T) | Track number |
| sd_valid | input | 1 | Sector byte available |
| sd_data | input | 8 | Sector byte |
| sd_ready | output | 1 | Controller takes the byte this cycle if sd_valid is high |
| mem_wr | output | 1 | Memory word write request |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_wdata | output | 32 | Word to write |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| irq | output | 1 | Completion or error interrupt |

## Verification
The bound checker watches a set of rules on every cycle. A pending write must hold its address and data until memory accepts it, and addresses must stay word-aligned. The byte port may only be ready while busy and with no write pending. The interrupt may only drop on a clear, and an out-of-range start must end idle with the interrupt raised and no write issued. The correctness of the geometry triple, of the packed word contents and of the address sequence, the unchanged result of a transfer that receives a second start, and the register readback can only be shown by the bench's scenarios, which compare each transfer's memory image with values computed from the block number.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_XFER = 1'b1
   } sdma_state_t;

   localparam logic [1:0] RA_CMD  = 2'd0;
   localparam logic [1:0] RA_LBN  = 2'd1;
   localparam logic [1:0] RA_DEST = 2'd2;
   localparam logic [1:0] RA_STAT = 2'd3;

   localparam int SB_BUSY = 0;
   localparam int SB_DONE = 1;
   localparam int SB_SERR = 2;
   localparam int SB_RERR = 3;
   localparam int SB_IRQ  = 4;
endpackage

// File: rtl/sdma_geometry.sv
module sdma_geometry #(
   parameter int LBN_W = 32,
   parameter int S     = 16,
   parameter int H     = 4,
   parameter int T     = 64,
   localparam int SEC_W  = $clog2(S),
   localparam int SURF_W = $clog2(H),
   localparam int TRK_W  = $clog2(T)
) (
   input  logic [LBN_W-1:0]  lbn,
   output logic [SEC_W-1:0]  sector,
   output logic [SURF_W-1:0] surface,
   output logic [TRK_W-1:0]  track
);
   localparam logic [LBN_W-1:0] PER_TRK = LBN_W'(S);
   localparam logic [LBN_W-1:0] PER_SRF = LBN_W'(H);
   localparam logic [LBN_W-1:0] PER_CYL = LBN_W'(S * H);

   logic [LBN_W-1:0] trk_index;

   always_comb begin
      trk_index = lbn / PER_TRK;
      sector    = SEC_W'(lbn % PER_TRK);
      surface   = SURF_W'(trk_index % PER_SRF);
      track     = TRK_W'(lbn / PER_CYL);
   end
endmodule

// File: rtl/sdma_packer.sv
module sdma_packer #(
   parameter bit MSB_FIRST = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        byte_take,
   input  logic [7:0]  byte_in,
   input  logic        word_take,
   output logic [31:0] word_q,
   output logic        pend
);
   logic [1:0] bcnt;
   logic [1:0] lane;

   generate
      if (MSB_FIRST) begin : g_msb
         assign lane = 2'd3 - bcnt;
      end else begin : g_lsb
         assign lane = bcnt;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bcnt   <= '0;
         word_q <= '0;
         pend   <= 1'b0;
      end else begin
         if (byte_take) begin
            word_q[8*lane +: 8] <= byte_in;
            bcnt                <= bcnt + 2'd1;
            if (bcnt == 2'd3) pend <= 1'b1;
         end
         if (word_take) pend <= 1'b0;
      end
   end
endmodule

// File: rtl/sector_dma_ctrl.sv
module sector_dma_ctrl
   import sdma_pkg::*;
#(
   parameter int SECTOR_BYTES    = 512,
   parameter int SECTS_PER_TRACK = 16,
   parameter int SURFACES        = 4,
   parameter int TRACKS          = 64,
   parameter int LBN_W           = 32,
   parameter int ADDR_W          = 32,
   parameter bit MSB_FIRST       = 1'b0,
   localparam int SEC_W  = $clog2(SECTS_PER_TRACK),
   localparam int SURF_W = $clog2(SURFACES),
   localparam int TRK_W  = $clog2(TRACKS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [1:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic [SEC_W-1:0]  chs_sector,
   output logic [SURF_W-1:0] chs_surface,
   output logic [TRK_W-1:0]  chs_track,
   input  logic              sd_valid,
   input  logic [7:0]        sd_data,
   output logic              sd_ready,
   output logic              mem_wr,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic              mem_ready,
   output logic              irq
);
   localparam int     WORDS    = SECTOR_BYTES / 4;
   localparam int     CNT_W    = $clog2(WORDS + 1);
   localparam longint CAPACITY = longint'(SECTS_PER_TRACK) * SURFACES * TRACKS;

   generate
      if (SECTOR_BYTES < 4 || (SECTOR_BYTES % 4) != 0) begin : g_bad_sector
         $error("sector size must be a positive multiple of four bytes");
      end
      if (SECTS_PER_TRACK < 2 || SURFACES < 2 || TRACKS < 2) begin : g_bad_geom
         $error("each geometry dimension must be at least two");
      end
      if (LBN_W > 32 || ADDR_W > 32 || ADDR_W < 3) begin : g_bad_width
         $error("register widths out of range");
      end
   endgenerate

   sdma_state_t       state;
   logic [LBN_W-1:0]  lbn_reg;
   logic [LBN_W-1:0]  lbn_q;
   logic [ADDR_W-1:0] dest_reg;
   logic [ADDR_W-1:0] waddr;
   logic [CNT_W-1:0]  wcnt;
   logic              done_f, serr_f, rerr_f, irq_f;
   logic              busy, start_cmd, clr_cmd, byte_take, word_take, pend;
   logic              lbn_bad, last_word;
   logic [31:0]       word_q;

   assign busy      = (state == ST_XFER);
   assign start_cmd = reg_wr_en && (reg_addr == RA_CMD) && reg_wdata[0];
   assign clr_cmd   = reg_wr_en && (reg_addr == RA_STAT) && reg_wdata[0];
   assign lbn_bad   = longint'(lbn_reg) >= CAPACITY;
   assign sd_ready  = busy && !pend;
   assign byte_take = sd_valid && sd_ready;
   assign word_take = pend && mem_ready;
   assign last_word = word_take && (wcnt == CNT_W'(WORDS - 1));

   sdma_geometry #(
      .LBN_W(LBN_W), .S(SECTS_PER_TRACK), .H(SURFACES), .T(TRACKS)
   ) u_geom (
      .lbn    (lbn_q),
      .sector (chs_sector),
      .surface(chs_surface),
      .track  (chs_track)
   );

   sdma_packer #(.MSB_FIRST(MSB_FIRST)) u_pack (
      .clk      (clk),
      .rst_n    (rst_n),
      .byte_take(byte_take),
      .byte_in  (sd_data),
      .word_take(word_take),
      .word_q   (word_q),
      .pend     (pend)
   );

   assign mem_wr    = pend;
   assign mem_addr  = waddr;
   assign mem_wdata = word_q;
   assign irq       = irq_f;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         lbn_reg  <= '0;
         lbn_q    <= '0;
         dest_reg <= '0;
         waddr    <= '0;
         wcnt     <= '0;
         done_f   <= 1'b0;
         serr_f   <= 1'b0;
         rerr_f   <= 1'b0;
         irq_f    <= 1'b0;
      end else begin
         if (reg_wr_en && reg_addr == RA_LBN)  lbn_reg  <= reg_wdata[LBN_W-1:0];
         if (reg_wr_en && reg_addr == RA_DEST) dest_reg <= reg_wdata[ADDR_W-1:0];
         if (clr_cmd) begin
            done_f <= 1'b0;
            serr_f <= 1'b0;
            rerr_f <= 1'b0;
            irq_f  <= 1'b0;
         end
         case (state)
            ST_IDLE: begin
               if (start_cmd) begin
                  if (lbn_bad) begin
                     rerr_f <= 1'b1;
                     irq_f  <= 1'b1;
                  end else begin
                     lbn_q <= lbn_reg;
                     waddr <= {dest_reg[ADDR_W-1:2], 2'b00};
                     wcnt  <= '0;
                     state <= ST_XFER;
                  end
               end
            end
            ST_XFER: begin
               if (start_cmd) serr_f <= 1'b1;
               if (word_take) begin
                  waddr <= waddr + ADDR_W'(4);
                  wcnt  <= wcnt + CNT_W'(1);
               end
               if (last_word) begin
                  state  <= ST_IDLE;
                  done_f <= 1'b1;
                  irq_f  <= 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RA_LBN:  reg_rdata = 32'(lbn_reg);
         RA_DEST: reg_rdata = 32'(dest_reg);
         RA_STAT: begin
            reg_rdata[SB_BUSY] = busy;
            reg_rdata[SB_DONE] = done_f;
            reg_rdata[SB_SERR] = serr_f;
            reg_rdata[SB_RERR] = rerr_f;
            reg_rdata[SB_IRQ]  = irq_f;
         end
         default: reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/sdma_checker.sv
module sdma_checker #(
   parameter int     LBN_W  = 32,
   parameter int     ADDR_W = 32,
   parameter longint CAP    = 4096
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr_en,
   input logic [1:0]        reg_addr,
   input logic [31:0]       reg_wdata,
   input logic              busy,
   input logic [LBN_W-1:0]  lbn_reg,
   input logic              sd_ready,
   input logic              mem_wr,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [31:0]       mem_wdata,
   input logic              mem_ready,
   input logic              irq
);
   logic clr_w, start_w;
   assign clr_w   = reg_wr_en && reg_addr == 2'd3 && reg_wdata[0];
   assign start_w = reg_wr_en && reg_addr == 2'd0 && reg_wdata[0];

   a_r4_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata)));

   a_r3_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> (mem_addr[1:0] == 2'b00));

   a_r10_ready_gated: assert property (@(posedge clk) disable iff (!rst_n)
      sd_ready |-> (busy && !mem_wr));

   a_r6_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !clr_w) |=> irq);

   a_r6_irq_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_w && !busy) |=> !irq);

   a_r8_range_reject: assert property (@(posedge clk) disable iff (!rst_n)
      (start_w && !busy && (longint'(lbn_reg) >= CAP)) |=> (irq && !busy && !mem_wr));

   a_r5_no_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_wr);
endmodule

bind sector_dma_ctrl sdma_checker #(
   .LBN_W(LBN_W), .ADDR_W(ADDR_W), .CAP(CAPACITY)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_wr_en(reg_wr_en),
   .reg_addr (reg_addr),
   .reg_wdata(reg_wdata),
   .busy     (busy),
   .lbn_reg  (lbn_reg),
   .sd_ready (sd_ready),
   .mem_wr   (mem_wr),
   .mem_addr (mem_addr),
   .mem_wdata(mem_wdata),
   .mem_ready(mem_ready),
   .irq      (irq)
);

// File: tb/sector_dma_ctrl_test.sv
module sector_dma_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int S = 16, H = 4, T = 64;
   localparam int CAP = S * H * T;
   localparam int NWORDS = 128;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [3:0]  chs_sector;
   logic [1:0]  chs_surface;
   logic [5:0]  chs_track;
   logic        sd_valid = 1'b0;
   logic [7:0]  sd_data = '0;
   logic        sd_ready;
   logic        mem_wr;
   logic [31:0] mem_addr;
   logic [31:0] mem_wdata;
   logic        mem_ready = 1'b0;
   logic        irq;

   always #(CLK_PERIOD/2) clk = ~clk;

   sector_dma_ctrl uut (
      .clk(clk), .rst_n(rst_n),
      .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .chs_sector(chs_sector), .chs_surface(chs_surface), .chs_track(chs_track),
      .sd_valid(sd_valid), .sd_data(sd_data), .sd_ready(sd_ready),
      .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
      .irq(irq)
   );

   int tests = 0, fails = 0;
   bit finished = 1'b0;

   int          cur_lbn = 0;
   int          byte_idx = 0;
   int          wr_cnt = 0, bad_cnt = 0;
   logic [31:0] exp_dest = '0;
   logic [31:0] img [NWORDS];
   int          val_pct = 100, rdy_pct = 100;
   bit          xfer_active = 1'b0;
   int          r10_viol = 0;

   function automatic logic [7:0] exp_byte(int l, int i);
      return 8'((l * 37) ^ (i * 11) ^ (i >> 4));
   endfunction

   function automatic logic [31:0] exp_word(int l, int k);
      return {exp_byte(l, 4*k+3), exp_byte(l, 4*k+2), exp_byte(l, 4*k+1), exp_byte(l, 4*k)};
   endfunction

   task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // sector source and memory sink, driven away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (sd_ready && (!xfer_active || mem_wr)) r10_viol++;
         sd_valid = (byte_idx < 4*NWORDS) && (($urandom % 100) < val_pct);
         sd_data  = exp_byte(cur_lbn, byte_idx);
         if (sd_valid && sd_ready) byte_idx++;
         mem_ready = (($urandom % 100) < rdy_pct);
         if (mem_wr && mem_ready) begin
            if (mem_addr >= exp_dest && mem_addr < exp_dest + 4*NWORDS && mem_addr[1:0] == 2'b00)
               img[(mem_addr - exp_dest) >> 2] = mem_wdata;
            else
               bad_cnt++;
            wr_cnt++;
         end
      end
   end

   task automatic reg_write(logic [1:0] a, logic [31:0] d);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic reg_read(logic [1:0] a, output logic [31:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic clear_irq();
      logic [31:0] st;
      reg_write(2'd3, 32'h1);
      reg_read(2'd3, st);
      check(irq == 1'b0, "R6", "irq after clear", 32'(irq), 0);
      check(st == 0, "R6", "status after clear", st, 0);
   endtask

   task automatic run_xfer(int lbn, logic [31:0] dest, int vp, int rp, bit poke);
      logic [31:0] st;
      int guard;
      int bad_words;
      cur_lbn = lbn; exp_dest = {dest[31:2], 2'b00};
      byte_idx = 0; wr_cnt = 0; bad_cnt = 0;
      val_pct = vp; rdy_pct = rp;
      for (int k = 0; k < NWORDS; k++) img[k] = 32'hDEAD_BEEF;
      reg_write(2'd1, 32'(lbn));
      reg_write(2'd2, dest);
      xfer_active = 1'b1;
      reg_write(2'd0, 32'h1);
      check(chs_sector == 4'(lbn % S), "R2", "sector", 32'(chs_sector), lbn % S);
      check(chs_surface == 2'((lbn / S) % H), "R2", "surface", 32'(chs_surface), (lbn / S) % H);
      check(chs_track == 6'(lbn / (S*H)), "R2", "track", 32'(chs_track), lbn / (S*H));
      if (poke) begin
         // R7: second start while busy must not disturb the transfer
         reg_write(2'd1, 32'((lbn + 5) % CAP));
         reg_write(2'd0, 32'h1);
         reg_read(2'd3, st);
         check(st[2] == 1'b1 && st[0] == 1'b1, "R7", "start error while busy", st, 32'h5);
         check(chs_sector == 4'(lbn % S), "R7", "geometry held", 32'(chs_sector), lbn % S);
      end
      guard = 0;
      while (!irq && guard < 20000) begin
         @(negedge clk); guard++;
      end
      xfer_active = 1'b0;
      check(guard < 20000, "R5", "completion within bound", guard, 20000);
      reg_read(2'd3, st);
      check(st[1] == 1'b1 && st[0] == 1'b0 && st[4] == 1'b1, "R5", "done status", st, 32'h12);
      check(wr_cnt == NWORDS && bad_cnt == 0, "R3", "write count/addresses", wr_cnt, NWORDS);
      bad_words = 0;
      for (int k = 0; k < NWORDS; k++) if (img[k] !== exp_word(lbn, k)) bad_words++;
      check(bad_words == 0, "R3", "memory image words wrong", bad_words, 0);
      repeat (6) @(negedge clk);
      check(irq == 1'b1, "R6", "irq held", 32'(irq), 1);
      clear_irq();
   endtask

   task automatic range_case(logic [31:0] lbn);
      logic [31:0] st;
      byte_idx = 0; wr_cnt = 0; bad_cnt = 0;
      reg_write(2'd1, lbn);
      reg_write(2'd0, 32'h1);
      reg_read(2'd3, st);
      check(irq == 1'b1, "R8", "irq on range error", 32'(irq), 1);
      check(st == 32'h18, "R8", "range status", st, 32'h18);
      repeat (20) @(negedge clk);
      check(wr_cnt == 0 && byte_idx == 0, "R8", "no data moved", wr_cnt + byte_idx, 0);
      clear_irq();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         tests++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      reg_read(2'd3, rd);
      check(irq == 0 && mem_wr == 0 && sd_ready == 0, "R1", "outputs after reset",
            {29'b0, irq, mem_wr, sd_ready}, 0);
      check(rd == 0, "R1", "status after reset", rd, 0);

      reg_write(2'd1, 32'd1234);
      reg_write(2'd2, 32'h0004_5670);
      reg_read(2'd1, rd);
      check(rd == 32'd1234, "R9", "block number readback", rd, 1234);
      reg_read(2'd2, rd);
      check(rd == 32'h0004_5670, "R9", "destination readback", rd, 32'h0004_5670);

      run_xfer(0, 32'h0000_1000, 100, 100, 1'b0);
      run_xfer(CAP - 1, 32'h0000_2002, 50, 40, 1'b0);
      run_xfer(777, 32'h0010_0000, 70, 60, 1'b1);
      range_case(32'(CAP));
      range_case(32'hFFFF_FFFF);
      for (int n = 0; n < 5; n++)
         run_xfer(int'($urandom % CAP), $urandom & 32'h0FFF_FFFF,
                  30 + int'($urandom % 71), 30 + int'($urandom % 71), n == 2);

      check(r10_viol == 0, "R10", "byte ready outside busy or with pending word", r10_viol, 0);
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule